// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Unit

This unit holds the completion-status word, the error flags and the two system configuration words of a NAND-style flash controller. Software reaches them through a small single-cycle register port. A separate command engine reports finished operations and failures as one-cycle event pulses. The unit turns the master completion bit into an interrupt pin whose active level software can choose. It also drives a ready pin from the configuration word.

The unit also gates new commands. A command written while the previous completion is still unacknowledged (master bit set) is thrown away. An accepted command is handed to the command engine as a one-cycle start pulse together with its code. Software acknowledges completions by writing a mask into the status word: the mask is ANDed into the word, and every zero in it clears that bit. If the acknowledge leaves the master bit clear, the error flags are wiped as well.

Register selects on `reg_addr_i`:

| Select | Register |
|---|---|
| 0 | completion status |
| 1 | error flags (read-only) |
| 2 | configuration 1 |
| 3 | configuration 2 |
| 4 | command |

Top module: `flash_irq_unit`

## Requirements
- R1: After `rst_ni` deasserts, the completion status reads 0x8080, configuration 1 reads 0x40C0, configuration 2 reads 0x0000, the error flags read 0x0000 and `rdy_o` is 1.
- R2: A `soft_rst_i` pulse loads the completion status with 0x8010, restores configuration 1 to 0x40C0, clears configuration 2 and the error flags, and sets `rdy_o` to 1.
- R3: Each `op_done_i` bit sets one status bit: bit 0 (reset) sets bit 4, bit 1 (erase) sets bit 5, bit 2 (program) sets bit 6 and bit 3 (load) sets bit 7. Any of these also sets master bit 15. `gen_done_i` sets bit 15 alone.
- R4: A write to select 0 ANDs the written value into the completion status. Ones keep bits and zeros clear them.
- R5: Each `op_err_i` bit sets one error flag: bit 0 (erase) sets flag bit 11, bit 1 (program) sets bit 12 and bit 2 (load) sets bit 13. Any of these also sets the command-error flag at bit 10. `cmd_err_i` sets bit 10 alone. Select 1 reads these flags with all other bits zero, and writes to select 1 have no effect.
- R6: A write to select 0 that leaves bit 15 clear wipes all error flags. A write that keeps bit 15 set leaves the flags unchanged.
- R7: `irq_o` equals status bit 15 XOR NOT configuration-1 bit 6, with no register between them. So bit 6 = 1 gives an active-high pin and bit 6 = 0 gives an active-low pin.
- R8: A write to configuration 1 sets `rdy_o` to written bit 7 in the next cycle.
- R9: Configuration 1 reads back with bits 4:0 forced to zero. Configuration 2 reads back exactly as written. Unused selects read 0.
- R10: A write to select 4 while bit 15 is clear is accepted. In the next cycle `cmd_start_o` pulses high for exactly one cycle and `cmd_code_o` and select 4 both show the code. A write to select 4 while bit 15 is set is dropped: there is no pulse and the stored code is unchanged.
- R11: An event arriving in the same cycle as a status write is applied after the AND. This applies to completion bits and to error flags that arrive while a wipe happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| soft_rst_i | input | 1 | Synchronous warm/hot reset pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register select |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the current select (combinational) |
| op_done_i | input | N_DONE | Per-operation completion pulses |
| gen_done_i | input | 1 | Generic completion pulse |
| op_err_i | input | N_DONE-1 | Per-operation error pulses (erase, program, load) |
| cmd_err_i | input | 1 | Generic command-error pulse |
| irq_o | output | 1 | Interrupt pin, polarity chosen by configuration |
| rdy_o | output | 1 | Ready pin |
| cmd_start_o | output | 1 | One-cycle start pulse for an accepted command |
| cmd_code_o | output | CMD_W | Code of the last accepted command |

## Verification
The bench builds the unit with its defaults: four completion sources, three operation error sources, a 16-bit command code and the 0x8080/0x8010/0x40C0 reset words. With these values every status bit and every flag bit is reachable. Both interrupt polarities can be reached by rewriting configuration 1. The remaining cases covered are: an acknowledge colliding with a fresh completion or a fresh error, a dropped command followed by an accepted one, and a warm reset from a dirty state.

// File: rtl/fiu_pkg.sv
package fiu_pkg;
  localparam int REG_W       = 16;
  localparam int MASTER_BIT  = 15;
  localparam int DONE_LSB    = 4;
  localparam int ERR_CMD_BIT = 10;
  localparam int ERR_OP_LSB  = 11;
  localparam int CFG_POL_BIT = 6;
  localparam int CFG_RDY_BIT = 7;
  localparam int CFG_RO_LSBS = 5;

  typedef enum logic [2:0] {
    SEL_INT  = 3'd0,
    SEL_ERR  = 3'd1,
    SEL_CFG1 = 3'd2,
    SEL_CFG2 = 3'd3,
    SEL_CMD  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/fiu_int_reg.sv
module fiu_int_reg
  import fiu_pkg::*;
#(
  parameter int               N_DONE   = 4,
  parameter logic [REG_W-1:0] COLD_VAL = 16'h8080,
  parameter logic [REG_W-1:0] WARM_VAL = 16'h8010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [N_DONE-1:0] op_done_i,
  input  logic             gen_done_i,
  output logic [REG_W-1:0] int_o,
  output logic             wipe_o
);
  logic [REG_W-1:0] int_q, set_v, and_v;

  always_comb begin
    set_v = '0;
    for (int i = 0; i < N_DONE; i++) set_v[DONE_LSB+i] = op_done_i[i];
    set_v[MASTER_BIT] = (|op_done_i) | gen_done_i;
  end

  assign and_v  = wr_en_i ? (int_q & wdata_i) : int_q;
  // wipe depends on the AND result only, not on same-cycle events
  assign wipe_o = wr_en_i & ~and_v[MASTER_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         int_q <= COLD_VAL;
    else if (soft_rst_i) int_q <= WARM_VAL;
    else                 int_q <= and_v | set_v;
  end

  assign int_o = int_q;
endmodule

// File: rtl/fiu_err_reg.sv
module fiu_err_reg
  import fiu_pkg::*;
#(
  parameter int N_ERR = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wipe_i,
  input  logic [N_ERR-1:0] op_err_i,
  input  logic             cmd_err_i,
  output logic [REG_W-1:0] err_o
);
  logic [REG_W-1:0] err_q, set_v;

  always_comb begin
    set_v = '0;
    for (int j = 0; j < N_ERR; j++) set_v[ERR_OP_LSB+j] = op_err_i[j];
    set_v[ERR_CMD_BIT] = (|op_err_i) | cmd_err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         err_q <= '0;
    else if (soft_rst_i) err_q <= '0;
    else                 err_q <= (wipe_i ? '0 : err_q) | set_v;
  end

  assign err_o = err_q;
endmodule

// File: rtl/fiu_cfg_reg.sv
module fiu_cfg_reg
  import fiu_pkg::*;
#(
  parameter logic [REG_W-1:0] CFG1_INIT = 16'h40C0,
  parameter logic [REG_W-1:0] CFG2_INIT = 16'h0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wr_cfg1_i,
  input  logic             wr_cfg2_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] cfg1_o,
  output logic [REG_W-1:0] cfg2_o,
  output logic             rdy_o
);
  logic [REG_W-1:0] cfg1_q, cfg2_q;
  logic             rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_q <= CFG1_INIT;
      cfg2_q <= CFG2_INIT;
      rdy_q  <= 1'b1;
    end else if (soft_rst_i) begin
      cfg1_q <= CFG1_INIT;
      cfg2_q <= CFG2_INIT;
      rdy_q  <= 1'b1;
    end else begin
      if (wr_cfg1_i) begin
        cfg1_q <= wdata_i;
        rdy_q  <= wdata_i[CFG_RDY_BIT];
      end
      if (wr_cfg2_i) cfg2_q <= wdata_i;
    end
  end

  assign cfg1_o = cfg1_q;
  assign cfg2_o = cfg2_q;
  assign rdy_o  = rdy_q;
endmodule

// File: rtl/flash_irq_unit.sv
module flash_irq_unit
  import fiu_pkg::*;
#(
  parameter int               ADDR_W    = 3,
  parameter int               N_DONE    = 4,
  parameter int               CMD_W     = 16,
  parameter logic [REG_W-1:0] COLD_INT  = 16'h8080,
  parameter logic [REG_W-1:0] WARM_INT  = 16'h8010,
  parameter logic [REG_W-1:0] CFG1_INIT = 16'h40C0,
  parameter logic [REG_W-1:0] CFG2_INIT = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [N_DONE-1:0] op_done_i,
  input  logic              gen_done_i,
  input  logic [N_DONE-2:0] op_err_i,
  input  logic              cmd_err_i,
  output logic              irq_o,
  output logic              rdy_o,
  output logic              cmd_start_o,
  output logic [CMD_W-1:0]  cmd_code_o
);
  localparam int N_ERR = N_DONE - 1;
  localparam logic [REG_W-1:0] CFG1_RD_MASK = ~REG_W'((1 << CFG_RO_LSBS) - 1);

  logic             hit_int, hit_cfg1, hit_cfg2, hit_cmd, cmd_accept, wipe;
  logic [REG_W-1:0] int_q, err_q, cfg1_q, cfg2_q;
  logic [CMD_W-1:0] cmd_q;
  logic             cmd_start_q;

  assign hit_int  = reg_we_i && (reg_addr_i == ADDR_W'(SEL_INT));
  assign hit_cfg1 = reg_we_i && (reg_addr_i == ADDR_W'(SEL_CFG1));
  assign hit_cfg2 = reg_we_i && (reg_addr_i == ADDR_W'(SEL_CFG2));
  assign hit_cmd  = reg_we_i && (reg_addr_i == ADDR_W'(SEL_CMD));

  fiu_int_reg #(.N_DONE(N_DONE), .COLD_VAL(COLD_INT), .WARM_VAL(WARM_INT)) i_int (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .wr_en_i(hit_int), .wdata_i(reg_wdata_i),
    .op_done_i(op_done_i), .gen_done_i(gen_done_i),
    .int_o(int_q), .wipe_o(wipe)
  );

  fiu_err_reg #(.N_ERR(N_ERR)) i_err (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .wipe_i(wipe), .op_err_i(op_err_i), .cmd_err_i(cmd_err_i),
    .err_o(err_q)
  );

  fiu_cfg_reg #(.CFG1_INIT(CFG1_INIT), .CFG2_INIT(CFG2_INIT)) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .wr_cfg1_i(hit_cfg1), .wr_cfg2_i(hit_cfg2), .wdata_i(reg_wdata_i),
    .cfg1_o(cfg1_q), .cfg2_o(cfg2_q), .rdy_o(rdy_o)
  );

  // new command only after the previous completion was acknowledged
  assign cmd_accept = hit_cmd & ~int_q[MASTER_BIT] & ~soft_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= '0;
      cmd_start_q <= 1'b0;
    end else begin
      cmd_start_q <= cmd_accept;
      if (cmd_accept) cmd_q <= CMD_W'(reg_wdata_i);
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_W'(SEL_INT):  reg_rdata_o = int_q;
      ADDR_W'(SEL_ERR):  reg_rdata_o = err_q;
      ADDR_W'(SEL_CFG1): reg_rdata_o = cfg1_q & CFG1_RD_MASK;
      ADDR_W'(SEL_CFG2): reg_rdata_o = cfg2_q;
      ADDR_W'(SEL_CMD):  reg_rdata_o = REG_W'(cmd_q);
      default:           reg_rdata_o = '0;
    endcase
  end

  assign irq_o       = int_q[MASTER_BIT] ^ ~cfg1_q[CFG_POL_BIT];
  assign cmd_start_o = cmd_start_q;
  assign cmd_code_o  = cmd_q;
endmodule

// File: rtl/flash_irq_unit_chk.sv
module flash_irq_unit_chk
  import fiu_pkg::*;
#(
  parameter int               ADDR_W   = 3,
  parameter int               N_DONE   = 4,
  parameter logic [REG_W-1:0] WARM_INT = 16'h8010
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [N_DONE-1:0] op_done_i,
  input logic              gen_done_i,
  input logic [N_DONE-2:0] op_err_i,
  input logic              cmd_err_i,
  input logic              rdy_o,
  input logic              cmd_start_o,
  input logic [REG_W-1:0]  int_q,
  input logic [REG_W-1:0]  err_q
);
  logic wr_int, wr_cmd, wr_cfg1, quiet;
  assign wr_int  = reg_we_i && reg_addr_i == ADDR_W'(SEL_INT);
  assign wr_cmd  = reg_we_i && reg_addr_i == ADDR_W'(SEL_CMD);
  assign wr_cfg1 = reg_we_i && reg_addr_i == ADDR_W'(SEL_CFG1);
  assign quiet   = !soft_rst_i && op_done_i == '0 && !gen_done_i;

  assert_soft_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (int_q == WARM_INT) && rdy_o && (err_q == '0));

  assert_done_sets_master_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && |op_done_i) |=> int_q[MASTER_BIT]);

  assert_and_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_int && quiet) |=> int_q == ($past(int_q) & $past(reg_wdata_i)));

  assert_err_sets_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && |op_err_i) |=> err_q[ERR_CMD_BIT]);

  assert_wipe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_int && !(int_q[MASTER_BIT] && reg_wdata_i[MASTER_BIT]) && !soft_rst_i
     && op_err_i == '0 && !cmd_err_i) |=> err_q == '0);

  assert_ready_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg1 && !soft_rst_i) |=> rdy_o == $past(reg_wdata_i[CFG_RDY_BIT]));

  assert_cmd_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && int_q[MASTER_BIT]) |=> !cmd_start_o);

  assert_cmd_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && !int_q[MASTER_BIT] && !soft_rst_i) |=> cmd_start_o);

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_o && !wr_cmd) |=> !cmd_start_o);
endmodule

bind flash_irq_unit flash_irq_unit_chk #(
  .ADDR_W(ADDR_W), .N_DONE(N_DONE), .WARM_INT(WARM_INT)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .op_done_i(op_done_i), .gen_done_i(gen_done_i), .op_err_i(op_err_i),
  .cmd_err_i(cmd_err_i), .rdy_o(rdy_o), .cmd_start_o(cmd_start_o),
  .int_q(int_q), .err_q(err_q)
);

// File: tb/test_flash_irq_unit.sv
module test_flash_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  done = '0;
  logic        gdone = 1'b0;
  logic [2:0]  err = '0;
  logic        cerr = 1'b0;
  logic        irq, rdy, cstart;
  logic [15:0] ccode;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_irq_unit i_flash_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .op_done_i(done), .gen_done_i(gdone), .op_err_i(err), .cmd_err_i(cerr),
    .irq_o(irq), .rdy_o(rdy), .cmd_start_o(cstart), .cmd_code_o(ccode)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    we = 0; done = '0; gdone = 0; err = '0; cerr = 0; soft_rst = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
    addr = a; #1; check(req, rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); idle(); we = 1; addr = a; wdata = d;
    @(posedge clk); #2; idle();
  endtask

  // we, addr, wdata, done, err, cerr, gdone, raddr, expected, expected irq
  localparam int NV = 17;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 3'd0, 16'h0000, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0}, // R4
    {1'b0, 3'd0, 16'h0000, 4'b0010, 3'b000, 1'b0, 1'b0, 3'd0, 16'h8020, 1'b1}, // R3
    {1'b0, 3'd0, 16'h0000, 4'b0000, 3'b010, 1'b0, 1'b0, 3'd1, 16'h1400, 1'b1}, // R5
    {1'b1, 3'd0, 16'hFFFF, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd1, 16'h1400, 1'b1}, // R6 keep
    {1'b1, 3'd0, 16'h7FFF, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd1, 16'h0000, 1'b0}, // R6 wipe
    {1'b0, 3'd0, 16'h0000, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd0, 16'h0020, 1'b0}, // R4
    {1'b0, 3'd0, 16'h0000, 4'b1000, 3'b100, 1'b0, 1'b0, 3'd1, 16'h2400, 1'b1}, // R5
    {1'b0, 3'd0, 16'h0000, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd0, 16'h80A0, 1'b1}, // R3
    {1'b1, 3'd2, 16'h0000, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd2, 16'h0000, 1'b0}, // R7 low
    {1'b1, 3'd2, 16'h00FF, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd2, 16'h00E0, 1'b1}, // R9
    {1'b1, 3'd3, 16'hA5A5, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd3, 16'hA5A5, 1'b1}, // R9
    {1'b1, 3'd0, 16'h0000, 4'b0000, 3'b000, 1'b0, 1'b1, 3'd1, 16'h0000, 1'b1}, // R11
    {1'b0, 3'd0, 16'h0000, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd0, 16'h8000, 1'b1}, // R11
    {1'b1, 3'd1, 16'hFFFF, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd1, 16'h0000, 1'b1}, // R5 ro
    {1'b1, 3'd0, 16'h0000, 4'b0000, 3'b000, 1'b1, 1'b0, 3'd1, 16'h0400, 1'b0}, // R11
    {1'b0, 3'd0, 16'h0000, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0}, // R7
    {1'b0, 3'd0, 16'h0000, 4'b0000, 3'b000, 1'b0, 1'b0, 3'd7, 16'h0000, 1'b0}  // R9
  };

  initial begin
    idle();
    #22 rst_n = 1;
    @(negedge clk);
    // R1 cold reset state
    rd("R1 int", 3'd0, 16'h8080);
    rd("R1 cfg1", 3'd2, 16'h40C0);
    rd("R1 cfg2", 3'd3, 16'h0000);
    rd("R1 err", 3'd1, 16'h0000);
    check("R1 rdy", {15'd0, rdy}, 16'd1);
    check("R7 irq at reset", {15'd0, irq}, 16'd1);

    for (int v = 0; v < NV; v++) begin
      logic [48:0] e;
      e = VEC[v];
      @(negedge clk);
      idle();
      we = e[48]; addr = e[47:45]; wdata = e[44:29]; done = e[28:25];
      err = e[24:22]; cerr = e[21]; gdone = e[20];
      @(posedge clk); #2;
      idle();
      rd($sformatf("R4/R5/R9/R11 vec %0d", v), e[19:17], e[16:1]);
      check($sformatf("R7 irq vec %0d", v), {15'd0, irq}, {15'd0, e[0]});
    end

    // R8 ready follows cfg1 bit 7
    wr(3'd2, 16'h0040);
    check("R8 rdy low", {15'd0, rdy}, 16'd0);
    rd("R9 cfg1 0040", 3'd2, 16'h0040);
    wr(3'd2, 16'h00C0);
    check("R8 rdy high", {15'd0, rdy}, 16'd1);

    // R10 command accept (status bit 15 clear here)
    wr(3'd4, 16'h0094);
    check("R10 start pulse", {15'd0, cstart}, 16'd1);
    check("R10 code", ccode, 16'h0094);
    @(posedge clk); #2;
    check("R10 pulse single", {15'd0, cstart}, 16'd0);
    @(negedge clk); gdone = 1; @(posedge clk); #2; idle();
    wr(3'd4, 16'h0030);
    check("R10 dropped no pulse", {15'd0, cstart}, 16'd0);
    rd("R10 dropped code kept", 3'd4, 16'h0094);
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0030);
    check("R10 accept after ack", {15'd0, cstart}, 16'd1);
    check("R10 new code", ccode, 16'h0030);

    // R2 warm reset from a dirty state
    @(negedge clk); cerr = 1; @(posedge clk); #2; idle();
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h1234);
    @(negedge clk); soft_rst = 1; @(posedge clk); #2; idle();
    rd("R2 int", 3'd0, 16'h8010);
    rd("R2 cfg1", 3'd2, 16'h40C0);
    rd("R2 cfg2", 3'd3, 16'h0000);
    rd("R2 err", 3'd1, 16'h0000);
    check("R2 rdy", {15'd0, rdy}, 16'd1);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog got=%0d exp=<5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule